// File: doc/BRIEF.md
# LCD Segment Line Scanner and Level Selector

This block drives the 64 segment columns of a dot-matrix liquid crystal panel, one scan line at a time. A 6-bit line counter is cleared by the frame pulse and stepped by the line clock. The sum of that counter and a display start line selects one bit-row of the display memory. The block reads that row through a combinational read port: it presents a page number and picks one bit out of every column byte. On the rising edge of the line clock it captures the 64 pixel bits. The counter advances on the falling edge, so the next row is ready before the next capture.

Each captured pixel bit is combined with the alternating polarity input and becomes a 2-bit voltage-level select for one segment output. A direction input reverses the order in which columns are mapped to output pins, and a display-enable input forces every output to its off level. The frame pulse and the line clock are slow strobes that the block samples with its own fast clock. Every edge takes effect at the first fast-clock edge that sees the new level.

The segment outputs are continuous level selects, not a stream of items, so they carry no valid/ready handshake and have no back-pressure. The memory read port is combinational and always answers in the same cycle. All pins are plain control or data pins.

Top module: `lcd_seg_scan`

## Requirements
- R1: At a fast-clock edge where `frame_sync` is sampled high after being low, the line counter becomes 0. This preset takes priority over a line-clock falling edge sampled at the same edge.
- R2: At a fast-clock edge where `line_clk` is sampled high after being low, the latch captures the 64 bits of the row selected by the line counter value held before that edge. The latch holds its contents at every other edge.
- R3: At a fast-clock edge where `line_clk` is sampled low after being high and no frame preset occurs, the line counter increases by 1, wrapping from 63 to 0.
- R4: When `col_dir` is 1, output k (bits 2k+1:2k of `seg_lvl`) is driven from column k. When `col_dir` is 0, output k is driven from column 63-k.
- R5: The row is (line counter + `start_line`) mod 64. `rd_page` equals row div 8. Column c takes bit (row mod 8) of `rd_data[8c+7:8c]`.
- R6: Each 2-bit level code is formed from the polarity input and the effective pixel bit. Polarity 0 with pixel 1 gives 00 (V0), and polarity 0 with pixel 0 gives 01 (V2). Polarity 1 with pixel 0 gives 10 (V3), and polarity 1 with pixel 1 gives 11 (V5). A change of polarity or direction shows on the outputs in the same cycle.
- R7: While `disp_on` is 0, every effective pixel bit is 0, so every output shows the off level for the current polarity. The latch is not altered, and the latched data reappears as soon as `disp_on` returns to 1.
- R8: During and right after reset, the line counter is 0 and the latch holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | Frame pulse; a rising level presets the line counter |
| line_clk | input | 1 | Line clock; rising level captures a row, falling level steps the counter |
| ac_pol | input | 1 | Alternating drive polarity |
| col_dir | input | 1 | Column-to-output order: 1 = straight, 0 = reversed |
| disp_on | input | 1 | Display enable; 0 forces off levels |
| start_line | input | 6 | Display start line added to the line counter |
| rd_page | output | 3 | Page (row div 8) addressed on the memory read port |
| rd_data | input | 512 | Byte of the addressed page for every column, column c in bits 8c+7:8c |
| seg_lvl | output | 128 | 2-bit level select per output, output k in bits 2k+1:2k |

## Verification
Two functions can fall in the same fast-clock cycle. A frame preset can coincide with a line-clock falling edge, where the preset must win. A frame preset can also coincide with a line-clock rising edge, where the capture must use the counter value from before the preset. The bench provokes both cases by switching the two strobes at the same instant. It judges the result with its own line counter and latch model, comparing `rd_page` and all 128 output bits on every clock. It also runs long enough for the counter to wrap, and it varies the start line, polarity, direction and display enable between runs of lines.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  // Voltage-level select codes for one segment output.
  typedef enum logic [1:0] {
    LV_V0 = 2'b00,
    LV_V2 = 2'b01,
    LV_V3 = 2'b10,
    LV_V5 = 2'b11
  } lvl_e;

  localparam int unsigned BITS_PER_BYTE = 8;

  // Map polarity and pixel bit to a level code.
  function automatic lvl_e lvl_code(input logic pol, input logic pix);
    lvl_e r;
    case ({pol, pix})
      2'b01:   r = LV_V0;
      2'b00:   r = LV_V2;
      2'b10:   r = LV_V3;
      default: r = LV_V5;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lcd_edge_det.sv
module lcd_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic evt
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= din;
  end

  generate
    if (RISING) begin : g_rise
      assign evt = din & ~q;
    end else begin : g_fall
      assign evt = ~din & q;
    end
  endgenerate
endmodule

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr #(
  parameter int unsigned NLINES = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       preset,
  input  logic                       adv,
  input  logic [$clog2(NLINES)-1:0]  start_line,
  output logic [$clog2(NLINES)-1:0]  z,
  output logic [$clog2(NLINES)-1:0]  row
);
  localparam int unsigned ZW = $clog2(NLINES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      z <= '0;
    else if (preset) z <= '0;
    else if (adv)    z <= z + ZW'(1);
  end

  // Wraps modulo NLINES (power of two).
  assign row = z + start_line;
endmodule

// File: rtl/lcd_row_latch.sv
module lcd_row_latch
  import lcd_seg_pkg::*;
#(
  parameter int unsigned NCOL = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [2:0]                    bit_sel,
  input  logic [NCOL*BITS_PER_BYTE-1:0] rd_data,
  output logic [NCOL-1:0]               lat
);
  logic [NCOL-1:0] pick;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign pick[c] = rd_data[c*BITS_PER_BYTE + int'(bit_sel)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat <= '0;
    else if (load) lat <= pick;
  end
endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map
  import lcd_seg_pkg::*;
#(
  parameter int unsigned NCOL = 64
) (
  input  logic [NCOL-1:0]   lat,
  input  logic              col_dir,
  input  logic              disp_on,
  input  logic              ac_pol,
  output logic [2*NCOL-1:0] seg_lvl
);
  for (genvar k = 0; k < NCOL; k++) begin : g_out
    logic pix;
    assign pix = disp_on & (col_dir ? lat[k] : lat[NCOL-1-k]);
    assign seg_lvl[2*k +: 2] = lvl_code(ac_pol, pix);
  end
endmodule

// File: rtl/lcd_seg_scan.sv
module lcd_seg_scan
  import lcd_seg_pkg::*;
#(
  parameter int unsigned NCOL   = 64,
  parameter int unsigned NLINES = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            frame_sync,
  input  logic                            line_clk,
  input  logic                            ac_pol,
  input  logic                            col_dir,
  input  logic                            disp_on,
  input  logic [$clog2(NLINES)-1:0]       start_line,
  output logic [$clog2(NLINES)-4:0]       rd_page,
  input  logic [NCOL*BITS_PER_BYTE-1:0]   rd_data,
  output logic [2*NCOL-1:0]               seg_lvl
);
  localparam int unsigned ZW = $clog2(NLINES);

  logic          frm_rise;
  logic          ln_rise;
  logic          ln_fall;
  logic [ZW-1:0] z_cnt;
  logic [ZW-1:0] row;
  logic [NCOL-1:0] lat_bits;

  lcd_edge_det #(.RISING(1'b1)) u_frm (
    .clk(clk), .rst_n(rst_n), .din(frame_sync), .evt(frm_rise));
  lcd_edge_det #(.RISING(1'b1)) u_lrise (
    .clk(clk), .rst_n(rst_n), .din(line_clk), .evt(ln_rise));
  lcd_edge_det #(.RISING(1'b0)) u_lfall (
    .clk(clk), .rst_n(rst_n), .din(line_clk), .evt(ln_fall));

  lcd_line_ctr #(.NLINES(NLINES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .preset(frm_rise), .adv(ln_fall),
    .start_line(start_line), .z(z_cnt), .row(row));

  assign rd_page = row[ZW-1:3];

  lcd_row_latch #(.NCOL(NCOL)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(ln_rise), .bit_sel(row[2:0]),
    .rd_data(rd_data), .lat(lat_bits));

  lcd_seg_map #(.NCOL(NCOL)) u_map (
    .lat(lat_bits), .col_dir(col_dir), .disp_on(disp_on),
    .ac_pol(ac_pol), .seg_lvl(seg_lvl));
endmodule

// File: rtl/lcd_seg_scan_chk.sv
module lcd_seg_scan_chk #(
  parameter int unsigned NCOL   = 64,
  parameter int unsigned NLINES = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       frm_rise,
  input logic                       ln_rise,
  input logic                       ln_fall,
  input logic [$clog2(NLINES)-1:0]  z_cnt,
  input logic [NCOL-1:0]            lat_bits,
  input logic                       disp_on,
  input logic                       ac_pol,
  input logic [2*NCOL-1:0]          seg_lvl
);
  localparam int unsigned ZW = $clog2(NLINES);

  a_r1_frame_preset: assert property (@(posedge clk) disable iff (!rst_n)
    frm_rise |=> (z_cnt == '0));

  a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_fall && !frm_rise) |=> (z_cnt == $past(z_cnt) + ZW'(1)));

  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ln_rise |=> $stable(lat_bits));

  a_r7_off_level: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (seg_lvl == {NCOL{ac_pol, ~ac_pol}}));

  a_r6_pol_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_lvl[1] == ac_pol) && (seg_lvl[2*NCOL-1] == ac_pol));
endmodule

bind lcd_seg_scan lcd_seg_scan_chk #(.NCOL(NCOL), .NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_rise(frm_rise), .ln_rise(ln_rise),
  .ln_fall(ln_fall), .z_cnt(z_cnt), .lat_bits(lat_bits),
  .disp_on(disp_on), .ac_pol(ac_pol), .seg_lvl(seg_lvl));

// File: tb/tb_lcd_seg_scan.sv
module tb_lcd_seg_scan;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_sync = 1'b0;
  logic         line_clk = 1'b0;
  logic         ac_pol = 1'b0;
  logic         col_dir = 1'b1;
  logic         disp_on = 1'b0;
  logic [5:0]   start_line = 6'd0;
  logic [2:0]   rd_page;
  logic [511:0] rd_data;
  logic [127:0] seg_lvl;

  logic [7:0] mem [64][8];

  int checks = 0;
  int fails  = 0;
  string cur_req = "R2";
  bit done = 1'b0;

  // Reference model state
  int      zref = 0;
  bit [63:0] lat_ref = '0;
  bit      pl = 1'b0, pf = 1'b0;

  always #2 clk = ~clk;

  lcd_seg_scan dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .line_clk(line_clk),
    .ac_pol(ac_pol), .col_dir(col_dir), .disp_on(disp_on),
    .start_line(start_line), .rd_page(rd_page), .rd_data(rd_data),
    .seg_lvl(seg_lvl));

  // Memory model: combinational read by page
  always_comb begin
    for (int c = 0; c < 64; c++) rd_data[c*8 +: 8] = mem[c][rd_page];
  end

  // Reference model, updated at every active edge
  always @(posedge clk) begin
    if (!rst_n) begin
      zref = 0; lat_ref = '0; pl = 1'b0; pf = 1'b0;
    end else begin
      int row;
      row = (zref + int'(start_line)) % 64;
      if (line_clk && !pl)
        for (int c = 0; c < 64; c++) lat_ref[c] = mem[c][row / 8][row % 8];
      if (frame_sync && !pf)        zref = 0;
      else if (!line_clk && pl)     zref = (zref + 1) % 64;
      pl = line_clk; pf = frame_sync;
    end
  end

  function automatic logic [127:0] exp_out();
    logic [127:0] e;
    for (int k = 0; k < 64; k++) begin
      bit b;
      b = lat_ref[col_dir ? k : 63 - k] & disp_on;
      e[2*k +: 2] = {ac_pol, ac_pol ? b : ~b};
    end
    return e;
  endfunction

  task automatic check_now();
    logic [2:0] ep;
    logic [127:0] eo;
    ep = 3'(((zref + int'(start_line)) % 64) / 8);
    eo = exp_out();
    checks++;
    if (rd_page !== ep) begin
      fails++;
      $display("FAIL R5 rd_page actual=%0d expected=%0d at %0t", rd_page, ep, $time);
    end
    checks++;
    if (seg_lvl !== eo) begin
      fails++;
      $display("FAIL %s seg_lvl actual=%h expected=%h at %0t", cur_req, seg_lvl, eo, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) check_now();

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic line_pulse();
    line_clk = 1'b1; step(3);
    line_clk = 1'b0; step(3);
  endtask

  task automatic frame_pulse();
    frame_sync = 1'b1; step(2);
    frame_sync = 1'b0; step(2);
  endtask

  initial begin
    for (int c = 0; c < 64; c++)
      for (int p = 0; p < 8; p++)
        mem[c][p] = 8'((c * 29 + p * 53 + 7) ^ (c << 2));
    step(4);
    rst_n = 1'b1;
    #0.5;
    // R8: after reset, latch clear and counter 0 -> page 0, off level for polarity 0
    checks++;
    if (seg_lvl !== {64{2'b01}} || rd_page !== 3'd0) begin
      fails++;
      $display("FAIL R8 reset seg_lvl actual=%h expected=%h page=%0d", seg_lvl, {64{2'b01}}, rd_page);
    end
    step(1);

    cur_req = "R2"; disp_on = 1'b1;
    frame_pulse();
    for (int i = 0; i < 70; i++) line_pulse();      // R3 wraps past 63
    cur_req = "R5"; start_line = 6'd45;
    frame_pulse();
    for (int i = 0; i < 20; i++) line_pulse();
    cur_req = "R6";
    for (int i = 0; i < 16; i++) begin ac_pol = ~ac_pol; line_pulse(); end
    cur_req = "R4"; col_dir = 1'b0;
    for (int i = 0; i < 12; i++) begin ac_pol = i[0]; line_pulse(); end
    cur_req = "R7"; disp_on = 1'b0;
    for (int i = 0; i < 4; i++) line_pulse();
    disp_on = 1'b1; step(3);
    // R1: frame rise together with line fall
    cur_req = "R1"; line_clk = 1'b1; step(3);
    line_clk = 1'b0; frame_sync = 1'b1; step(3);
    frame_sync = 1'b0; step(2);
    // R1/R2: frame rise together with line rise
    line_pulse(); line_pulse();
    line_clk = 1'b1; frame_sync = 1'b1; step(3);
    line_clk = 1'b0; frame_sync = 1'b0; step(3);
    for (int i = 0; i < 5; i++) line_pulse();
    cur_req = "R3"; start_line = 6'd63; col_dir = 1'b1;
    for (int i = 0; i < 66; i++) line_pulse();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule